// File: doc/BRIEF.md
# Debug Breakpoint Trigger Unit

This block watches a processor's local bus and flags a breakpoint when a programmed condition matches the current bus cycle. It has three kinds of comparator. Four program-counter comparators check the fetch address for an exact match, and each can also require that the address space identifier match. Two operand-address sets check an inclusive address range, masked bus attributes and an optional identifier. One data comparator checks the bus data under a per-bit ignore mask.

A single-cycle register write port stands for both the serial debug port and supervisor-mode writes. A separate debug memory command port carries the debug memory accesses. With the build parameter `SHARED_RES` set, those accesses reuse the first address set's high register, the low byte of its attribute register and the data comparator's value register, and so overwrite them. With the parameter clear, debug commands leave every breakpoint register untouched.

The outputs are registered. A per-comparator hit vector and a combined trigger pulse appear one clock after the bus cycle that matched.

Top module: `bkpt_trigger_unit`

## Requirements
- R1: While `rst` is high (synchronous, active high), the next clock clears `hit_vec` and `trig_pulse`. Reset also clears every comparator enable, so no traffic produces a hit until software programs an enable.
- R2: Program-counter comparator p (p = 0..3) drives `hit_vec[p]` when its enable is set and `bus_pc` equals its address register. The address register is register index p. Index 4 holds the enables in bits [3:0].
- R3: Bits [7:4] of register index 4 select identifier qualification for each program-counter comparator. A qualified comparator also needs `bus_asid` to equal the shared identifier value held in bits [7:0] of register index 5. An unqualified comparator ignores `bus_asid`.
- R4: Address set k (k = 0,1) uses register indices 6+3k (low), 7+3k (high) and 8+3k (attribute). It drives `hit_vec[4+k]` only when low <= `bus_addr` <= high, with unsigned 32-bit comparisons that include both bounds. Its enable is bit k of register index 14.
- R5: Attribute register fields are: bits [7:0] the expected attribute value, bits [15:8] a compare mask (1 = compare that bit). An address set hits only if `bus_attr` equals the value on every compared bit. Set 0 uses the first attribute register and set 1 uses the second.
- R6: Attribute register bits [23:16] hold an identifier and bit 24 enables it. When bit 24 is set, the set hits only if `bus_asid` equals that identifier. When bit 24 is clear, `bus_asid` has no effect.
- R7: The data comparator uses register index 12 (value) and index 13 (mask, 1 = ignore that bit). It drives `hit_vec[6]` when `bus_data` equals the value on every unmasked bit. Its enable is bit 2 of register index 14.
- R8: A register write takes effect from the clock after it is presented. A bus cycle is evaluated with the registers as they were before that clock edge. Only cycles with `bus_valid` high are evaluated, and each such cycle gives a one-clock result on the next cycle. With `bus_valid` low, the next `hit_vec` is zero.
- R9: `trig_pulse` is high exactly when any bit of `hit_vec` is high, in the same cycle.
- R10: With `SHARED_RES` = 1, a debug memory command (`dbg_cmd_valid`) loads `dbg_cmd_addr` into the high register of address set 0. It also loads `dbg_cmd_attr` into bits [7:0] of the first attribute register, replacing the programmed values. If a register write targets the same register in the same cycle, the command wins.
- R11: With `SHARED_RES` = 1, a debug write command (`dbg_cmd_valid` and `dbg_cmd_write`) also loads `dbg_cmd_data` into the data comparator's value register.
- R12: With `SHARED_RES` = 0, debug memory commands change no breakpoint register, so later matching behaves as if no command had been issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | REG_AW (4) | Register index |
| cfg_wdata | input | DATA_W (32) | Register write data |
| dbg_cmd_valid | input | 1 | Debug memory command present |
| dbg_cmd_write | input | 1 | Debug command is a write |
| dbg_cmd_addr | input | DATA_W (32) | Debug command address |
| dbg_cmd_attr | input | ATTR_W (8) | Debug command bus attributes |
| dbg_cmd_data | input | DATA_W (32) | Debug write data |
| bus_valid | input | 1 | Bus cycle qualifier |
| bus_pc | input | DATA_W (32) | Program counter of the cycle |
| bus_addr | input | DATA_W (32) | Operand address of the cycle |
| bus_data | input | DATA_W (32) | Data of the cycle |
| bus_attr | input | ATTR_W (8) | Bus attributes of the cycle |
| bus_asid | input | ID_W (8) | Address space identifier of the cycle |
| hit_vec | output | NHIT (7) | Registered per-comparator hits: [3:0] program counter, [5:4] address sets, [6] data |
| trig_pulse | output | 1 | Registered OR of all hits |

## Verification
The assertions assume that `rst` is high at the first clock edge and that `bus_valid` is a clean level sampled at each edge. They also assume that an enable sampled one clock earlier governs the hit seen now. The stimulus drives all inputs only at falling edges and holds reset across the first edges. Register writes and debug commands are issued as single-cycle strobes. One case deliberately presents a write and a bus cycle in the same clock, to exercise the ordering rule. Two instances, one per resource mode, receive identical traffic so that the overwrite and no-overwrite behaviours are compared against the same program.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  // Register index layout derived from the comparator counts.
  function automatic int unsigned idx_pc_ctl(int unsigned npc);
    return npc;
  endfunction

  function automatic int unsigned idx_pc_id(int unsigned npc);
    return npc + 1;
  endfunction

  // field: 0 = low bound, 1 = high bound, 2 = attribute
  function automatic int unsigned idx_set(int unsigned npc, int unsigned k, int unsigned field);
    return npc + 2 + 3 * k + field;
  endfunction

  function automatic int unsigned idx_dval(int unsigned npc, int unsigned nset);
    return npc + 2 + 3 * nset;
  endfunction

  function automatic int unsigned idx_dmsk(int unsigned npc, int unsigned nset);
    return npc + 3 + 3 * nset;
  endfunction

  function automatic int unsigned idx_misc_en(int unsigned npc, int unsigned nset);
    return npc + 4 + 3 * nset;
  endfunction
endpackage

// File: rtl/bkpt_regs.sv
module bkpt_regs #(
  parameter int NUM_PC     = 4,
  parameter int NUM_ADDR   = 2,
  parameter int DATA_W     = 32,
  parameter int ATTR_W     = 8,
  parameter int ID_W       = 8,
  parameter int SHARED_RES = 0,
  parameter int REG_AW     = 4
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               cfg_we,
  input  logic [REG_AW-1:0]                  cfg_addr,
  input  logic [DATA_W-1:0]                  cfg_wdata,
  input  logic                               dbg_cmd_valid,
  input  logic                               dbg_cmd_write,
  input  logic [DATA_W-1:0]                  dbg_cmd_addr,
  input  logic [ATTR_W-1:0]                  dbg_cmd_attr,
  input  logic [DATA_W-1:0]                  dbg_cmd_data,
  output logic [NUM_PC-1:0][DATA_W-1:0]      pc_bp,
  output logic [NUM_PC-1:0]                  pc_en,
  output logic [NUM_PC-1:0]                  pc_idq,
  output logic [ID_W-1:0]                    pc_id,
  output logic [NUM_ADDR-1:0][DATA_W-1:0]    set_lo,
  output logic [NUM_ADDR-1:0][DATA_W-1:0]    set_hi,
  output logic [NUM_ADDR-1:0][ATTR_W-1:0]    set_aval,
  output logic [NUM_ADDR-1:0][ATTR_W-1:0]    set_amsk,
  output logic [NUM_ADDR-1:0][ID_W-1:0]      set_id,
  output logic [NUM_ADDR-1:0]                set_iden,
  output logic [NUM_ADDR-1:0]                set_en,
  output logic [DATA_W-1:0]                  dat_val,
  output logic [DATA_W-1:0]                  dat_msk,
  output logic                               dat_en
);
  import bkpt_pkg::*;

  localparam int MSK_LO = ATTR_W;
  localparam int ID_LO  = 2 * ATTR_W;
  localparam int IDEN_B = 2 * ATTR_W + ID_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_bp    <= '0;
      pc_en    <= '0;
      pc_idq   <= '0;
      pc_id    <= '0;
      set_lo   <= '0;
      set_hi   <= '0;
      set_aval <= '0;
      set_amsk <= '0;
      set_id   <= '0;
      set_iden <= '0;
      set_en   <= '0;
      dat_val  <= '0;
      dat_msk  <= '0;
      dat_en   <= 1'b0;
    end else begin
      if (cfg_we) begin
        for (int i = 0; i < NUM_PC; i++) begin
          if (cfg_addr == REG_AW'(i)) pc_bp[i] <= cfg_wdata;
        end
        if (cfg_addr == REG_AW'(idx_pc_ctl(NUM_PC))) begin
          pc_en  <= cfg_wdata[NUM_PC-1:0];
          pc_idq <= cfg_wdata[2*NUM_PC-1:NUM_PC];
        end
        if (cfg_addr == REG_AW'(idx_pc_id(NUM_PC))) pc_id <= cfg_wdata[ID_W-1:0];
        for (int k = 0; k < NUM_ADDR; k++) begin
          if (cfg_addr == REG_AW'(idx_set(NUM_PC, k, 0))) set_lo[k] <= cfg_wdata;
          if (cfg_addr == REG_AW'(idx_set(NUM_PC, k, 1))) set_hi[k] <= cfg_wdata;
          if (cfg_addr == REG_AW'(idx_set(NUM_PC, k, 2))) begin
            set_aval[k] <= cfg_wdata[ATTR_W-1:0];
            set_amsk[k] <= cfg_wdata[MSK_LO +: ATTR_W];
            set_id[k]   <= cfg_wdata[ID_LO +: ID_W];
            set_iden[k] <= cfg_wdata[IDEN_B];
          end
        end
        if (cfg_addr == REG_AW'(idx_dval(NUM_PC, NUM_ADDR))) dat_val <= cfg_wdata;
        if (cfg_addr == REG_AW'(idx_dmsk(NUM_PC, NUM_ADDR))) dat_msk <= cfg_wdata;
        if (cfg_addr == REG_AW'(idx_misc_en(NUM_PC, NUM_ADDR))) begin
          set_en <= cfg_wdata[NUM_ADDR-1:0];
          dat_en <= cfg_wdata[NUM_ADDR];
        end
      end
      // Shared-resource build: debug commands borrow breakpoint storage.
      if (SHARED_RES != 0 && dbg_cmd_valid) begin
        set_hi[0]   <= dbg_cmd_addr;
        set_aval[0] <= dbg_cmd_attr;
        if (dbg_cmd_write) dat_val <= dbg_cmd_data;
      end
    end
  end
endmodule

// File: rtl/bkpt_pc_cmp.sv
module bkpt_pc_cmp #(
  parameter int DATA_W = 32,
  parameter int ID_W   = 8
) (
  input  logic              en,
  input  logic              idq,
  input  logic [DATA_W-1:0] bp,
  input  logic [ID_W-1:0]   id_ref,
  input  logic [DATA_W-1:0] bus_pc,
  input  logic [ID_W-1:0]   bus_asid,
  output logic              match
);
  logic id_ok;
  assign id_ok = !idq || (id_ref == bus_asid);
  assign match = en && (bp == bus_pc) && id_ok;
endmodule

// File: rtl/bkpt_addr_cmp.sv
module bkpt_addr_cmp #(
  parameter int DATA_W = 32,
  parameter int ATTR_W = 8,
  parameter int ID_W   = 8
) (
  input  logic              en,
  input  logic [DATA_W-1:0] lo,
  input  logic [DATA_W-1:0] hi,
  input  logic [ATTR_W-1:0] aval,
  input  logic [ATTR_W-1:0] amsk,
  input  logic [ID_W-1:0]   id_ref,
  input  logic              iden,
  input  logic [DATA_W-1:0] bus_addr,
  input  logic [ATTR_W-1:0] bus_attr,
  input  logic [ID_W-1:0]   bus_asid,
  output logic              match
);
  logic in_range, attr_ok, id_ok;
  assign in_range = (lo <= bus_addr) && (bus_addr <= hi);
  assign attr_ok  = ((bus_attr ^ aval) & amsk) == '0;
  assign id_ok    = !iden || (id_ref == bus_asid);
  assign match    = en && in_range && attr_ok && id_ok;
endmodule

// File: rtl/bkpt_data_cmp.sv
module bkpt_data_cmp #(
  parameter int DATA_W = 32
) (
  input  logic              en,
  input  logic [DATA_W-1:0] dval,
  input  logic [DATA_W-1:0] dmsk,
  input  logic [DATA_W-1:0] bus_data,
  output logic              match
);
  assign match = en && (((bus_data ^ dval) & ~dmsk) == '0);
endmodule

// File: rtl/bkpt_trigger_unit.sv
module bkpt_trigger_unit #(
  parameter int NUM_PC     = 4,
  parameter int NUM_ADDR   = 2,
  parameter int DATA_W     = 32,
  parameter int ATTR_W     = 8,
  parameter int ID_W       = 8,
  parameter int SHARED_RES = 0,
  parameter int REG_AW     = $clog2(NUM_PC + 5 + 3 * NUM_ADDR),
  parameter int NHIT       = NUM_PC + NUM_ADDR + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              dbg_cmd_valid,
  input  logic              dbg_cmd_write,
  input  logic [DATA_W-1:0] dbg_cmd_addr,
  input  logic [ATTR_W-1:0] dbg_cmd_attr,
  input  logic [DATA_W-1:0] dbg_cmd_data,
  input  logic              bus_valid,
  input  logic [DATA_W-1:0] bus_pc,
  input  logic [DATA_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [ATTR_W-1:0] bus_attr,
  input  logic [ID_W-1:0]   bus_asid,
  output logic [NHIT-1:0]   hit_vec,
  output logic              trig_pulse
);
  localparam int SET_BASE = NUM_PC;
  localparam int DAT_BIT  = NUM_PC + NUM_ADDR;

  logic [NUM_PC-1:0][DATA_W-1:0]   pc_bp;
  logic [NUM_PC-1:0]               pc_en, pc_idq;
  logic [ID_W-1:0]                 pc_id;
  logic [NUM_ADDR-1:0][DATA_W-1:0] set_lo, set_hi;
  logic [NUM_ADDR-1:0][ATTR_W-1:0] set_aval, set_amsk;
  logic [NUM_ADDR-1:0][ID_W-1:0]   set_id;
  logic [NUM_ADDR-1:0]             set_iden, set_en;
  logic [DATA_W-1:0]               dat_val, dat_msk;
  logic                            dat_en;
  logic [NHIT-1:0]                 hits_c;

  bkpt_regs #(
    .NUM_PC(NUM_PC), .NUM_ADDR(NUM_ADDR), .DATA_W(DATA_W), .ATTR_W(ATTR_W),
    .ID_W(ID_W), .SHARED_RES(SHARED_RES), .REG_AW(REG_AW)
  ) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .dbg_cmd_valid(dbg_cmd_valid), .dbg_cmd_write(dbg_cmd_write),
    .dbg_cmd_addr(dbg_cmd_addr), .dbg_cmd_attr(dbg_cmd_attr), .dbg_cmd_data(dbg_cmd_data),
    .pc_bp(pc_bp), .pc_en(pc_en), .pc_idq(pc_idq), .pc_id(pc_id),
    .set_lo(set_lo), .set_hi(set_hi), .set_aval(set_aval), .set_amsk(set_amsk),
    .set_id(set_id), .set_iden(set_iden), .set_en(set_en),
    .dat_val(dat_val), .dat_msk(dat_msk), .dat_en(dat_en)
  );

  for (genvar p = 0; p < NUM_PC; p++) begin : g_pc
    bkpt_pc_cmp #(.DATA_W(DATA_W), .ID_W(ID_W)) u_cmp (
      .en(pc_en[p]), .idq(pc_idq[p]), .bp(pc_bp[p]), .id_ref(pc_id),
      .bus_pc(bus_pc), .bus_asid(bus_asid), .match(hits_c[p])
    );
  end

  for (genvar k = 0; k < NUM_ADDR; k++) begin : g_set
    bkpt_addr_cmp #(.DATA_W(DATA_W), .ATTR_W(ATTR_W), .ID_W(ID_W)) u_cmp (
      .en(set_en[k]), .lo(set_lo[k]), .hi(set_hi[k]),
      .aval(set_aval[k]), .amsk(set_amsk[k]), .id_ref(set_id[k]), .iden(set_iden[k]),
      .bus_addr(bus_addr), .bus_attr(bus_attr), .bus_asid(bus_asid),
      .match(hits_c[SET_BASE+k])
    );
  end

  bkpt_data_cmp #(.DATA_W(DATA_W)) u_dat (
    .en(dat_en), .dval(dat_val), .dmsk(dat_msk), .bus_data(bus_data),
    .match(hits_c[DAT_BIT])
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_vec    <= '0;
      trig_pulse <= 1'b0;
    end else begin
      hit_vec    <= bus_valid ? hits_c : '0;
      trig_pulse <= bus_valid && (hits_c != '0);
    end
  end
endmodule

// File: rtl/bkpt_trigger_checker.sv
module bkpt_trigger_checker #(
  parameter int NUM_PC   = 4,
  parameter int NUM_ADDR = 2,
  parameter int NHIT     = 7
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_valid,
  input logic [NHIT-1:0]     hit_vec,
  input logic                trig_pulse,
  input logic [NUM_PC-1:0]   pc_en,
  input logic [NUM_ADDR-1:0] set_en,
  input logic                dat_en
);
  localparam int DAT_BIT = NUM_PC + NUM_ADDR;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (hit_vec == '0 && !trig_pulse)); // R1

  AST_IDLE_BUS_NO_HIT: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |=> (hit_vec == '0)); // R8

  AST_PULSE_MATCHES_VEC: assert property (@(posedge clk) disable iff (rst)
    trig_pulse == (hit_vec != '0)); // R9

  AST_PC_HIT_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    (hit_vec[NUM_PC-1:0] & ~$past(pc_en)) == '0); // R2

  AST_SET_HIT_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    (hit_vec[DAT_BIT-1:NUM_PC] & ~$past(set_en)) == '0); // R4

  AST_DATA_HIT_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    hit_vec[DAT_BIT] |-> $past(dat_en)); // R7
endmodule

bind bkpt_trigger_unit bkpt_trigger_checker #(
  .NUM_PC(NUM_PC), .NUM_ADDR(NUM_ADDR), .NHIT(NHIT)
) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .hit_vec(hit_vec),
  .trig_pulse(trig_pulse), .pc_en(pc_en), .set_en(set_en), .dat_en(dat_en)
);

// File: tb/test_bkpt_trigger_unit.sv
`timescale 1ns/1ps
module test_bkpt_trigger_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        dbg_cmd_valid = 1'b0, dbg_cmd_write = 1'b0;
  logic [31:0] dbg_cmd_addr = '0, dbg_cmd_data = '0;
  logic [7:0]  dbg_cmd_attr = '0;
  logic        bus_valid = 1'b0;
  logic [31:0] bus_pc = '0, bus_addr = '0, bus_data = '0;
  logic [7:0]  bus_attr = '0, bus_asid = '0;
  logic [6:0]  hv0, hv1;
  logic        tp0, tp1;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";

  always #4 clk = ~clk; // 125 MHz

  bkpt_trigger_unit #(.SHARED_RES(0)) i_bkpt_trigger_unit (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .dbg_cmd_valid(dbg_cmd_valid), .dbg_cmd_write(dbg_cmd_write), .dbg_cmd_addr(dbg_cmd_addr),
    .dbg_cmd_attr(dbg_cmd_attr), .dbg_cmd_data(dbg_cmd_data), .bus_valid(bus_valid),
    .bus_pc(bus_pc), .bus_addr(bus_addr), .bus_data(bus_data), .bus_attr(bus_attr),
    .bus_asid(bus_asid), .hit_vec(hv0), .trig_pulse(tp0));

  bkpt_trigger_unit #(.SHARED_RES(1)) i_bkpt_trigger_unit_shr (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .dbg_cmd_valid(dbg_cmd_valid), .dbg_cmd_write(dbg_cmd_write), .dbg_cmd_addr(dbg_cmd_addr),
    .dbg_cmd_attr(dbg_cmd_attr), .dbg_cmd_data(dbg_cmd_data), .bus_valid(bus_valid),
    .bus_pc(bus_pc), .bus_addr(bus_addr), .bus_data(bus_data), .bus_attr(bus_attr),
    .bus_asid(bus_asid), .hit_vec(hv1), .trig_pulse(tp1));

  // Behavioural reference: index 0 = separate resources, 1 = shared resources.
  logic [31:0] m_pc   [2][4];
  logic [3:0]  m_pcen [2];
  logic [3:0]  m_idq  [2];
  logic [7:0]  m_pcid [2];
  logic [31:0] m_lo   [2][2];
  logic [31:0] m_hi   [2][2];
  logic [7:0]  m_av   [2][2];
  logic [7:0]  m_am   [2][2];
  logic [7:0]  m_aid  [2][2];
  logic        m_aiden[2][2];
  logic [31:0] m_dv   [2];
  logic [31:0] m_dm   [2];
  logic [1:0]  m_sen  [2];
  logic        m_den  [2];
  logic [6:0]  exp_hit[2] = '{7'd0, 7'd0};

  task automatic model_step(input int u);
    logic [6:0] h;
    if (rst) begin
      for (int p = 0; p < 4; p++) m_pc[u][p] = '0;
      for (int k = 0; k < 2; k++) begin
        m_lo[u][k] = '0; m_hi[u][k] = '0; m_av[u][k] = '0;
        m_am[u][k] = '0; m_aid[u][k] = '0; m_aiden[u][k] = 1'b0;
      end
      m_pcen[u] = '0; m_idq[u] = '0; m_pcid[u] = '0;
      m_dv[u] = '0; m_dm[u] = '0; m_sen[u] = '0; m_den[u] = 1'b0;
      exp_hit[u] = '0;
    end else begin
      h = '0;
      if (bus_valid) begin
        for (int p = 0; p < 4; p++)
          h[p] = m_pcen[u][p] && (bus_pc == m_pc[u][p]) &&
                 (!m_idq[u][p] || bus_asid == m_pcid[u]);
        for (int k = 0; k < 2; k++)
          h[4+k] = m_sen[u][k] && (bus_addr >= m_lo[u][k]) && (bus_addr <= m_hi[u][k]) &&
                   ((bus_attr & m_am[u][k]) == (m_av[u][k] & m_am[u][k])) &&
                   (!m_aiden[u][k] || bus_asid == m_aid[u][k]);
        h[6] = m_den[u] && ((bus_data | m_dm[u]) == (m_dv[u] | m_dm[u]));
      end
      exp_hit[u] = h;
      if (cfg_we) begin
        if (cfg_addr < 4) m_pc[u][cfg_addr[1:0]] = cfg_wdata;
        else if (cfg_addr == 4) begin m_pcen[u] = cfg_wdata[3:0]; m_idq[u] = cfg_wdata[7:4]; end
        else if (cfg_addr == 5) m_pcid[u] = cfg_wdata[7:0];
        else if (cfg_addr >= 6 && cfg_addr <= 11) begin
          int k; int f;
          k = (int'(cfg_addr) - 6) / 3;
          f = (int'(cfg_addr) - 6) % 3;
          if (f == 0) m_lo[u][k] = cfg_wdata;
          else if (f == 1) m_hi[u][k] = cfg_wdata;
          else begin
            m_av[u][k] = cfg_wdata[7:0]; m_am[u][k] = cfg_wdata[15:8];
            m_aid[u][k] = cfg_wdata[23:16]; m_aiden[u][k] = cfg_wdata[24];
          end
        end
        else if (cfg_addr == 12) m_dv[u] = cfg_wdata;
        else if (cfg_addr == 13) m_dm[u] = cfg_wdata;
        else if (cfg_addr == 14) begin m_sen[u] = cfg_wdata[1:0]; m_den[u] = cfg_wdata[2]; end
      end
      if (u == 1 && dbg_cmd_valid) begin // R10 / R11 overwrite rules
        m_hi[u][0] = dbg_cmd_addr;
        m_av[u][0] = dbg_cmd_attr;
        if (dbg_cmd_write) m_dv[u] = dbg_cmd_data;
      end
    end
  endtask

  always @(posedge clk) begin
    model_step(0);
    model_step(1);
  end

  // Compare every cycle, away from the active edge (trig_pulse covers R9).
  always @(negedge clk) begin
    checks++;
    if (hv0 !== exp_hit[0] || tp0 !== (|exp_hit[0])) begin
      failures++;
      $display("FAIL %s separate: hit=%b trig=%b expected hit=%b trig=%b",
               cur_req, hv0, tp0, exp_hit[0], |exp_hit[0]);
    end
    checks++;
    if (hv1 !== exp_hit[1] || tp1 !== (|exp_hit[1])) begin
      failures++;
      $display("FAIL %s shared: hit=%b trig=%b expected hit=%b trig=%b",
               cur_req, hv1, tp1, exp_hit[1], |exp_hit[1]);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cyc(input logic [31:0] pc, input logic [31:0] ad, input logic [31:0] da,
                     input logic [7:0] at, input logic [7:0] id);
    @(negedge clk);
    bus_valid = 1'b1; bus_pc = pc; bus_addr = ad; bus_data = da; bus_attr = at; bus_asid = id;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic cmd(input logic w, input logic [31:0] ad, input logic [7:0] at,
                     input logic [31:0] da);
    @(negedge clk);
    dbg_cmd_valid = 1'b1; dbg_cmd_write = w; dbg_cmd_addr = ad;
    dbg_cmd_attr = at; dbg_cmd_data = da;
    @(negedge clk);
    dbg_cmd_valid = 1'b0;
  endtask

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cyc(32'h0, 32'h0, 32'h0, 8'h00, 8'h00);
    cyc(32'h1000, 32'h2000, 32'hFFFF_FFFF, 8'hFF, 8'h05);

    cur_req = "R2";
    wr(4'd0, 32'h1000); wr(4'd1, 32'h1004); wr(4'd2, 32'h1008); wr(4'd3, 32'h100C);
    wr(4'd4, 32'h0000_000F);
    cyc(32'h1000, 0, 0, 0, 0);
    cyc(32'h100C, 0, 0, 0, 0);
    cyc(32'h1010, 0, 0, 0, 0);

    cur_req = "R8";
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'd4; cfg_wdata = 32'h0;
    bus_valid = 1'b1; bus_pc = 32'h1000;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
    bus_valid = 1'b0;
    wr(4'd4, 32'h0000_000F);

    cur_req = "R3";
    wr(4'd5, 32'h05); wr(4'd4, 32'h0000_004F);
    cyc(32'h1008, 0, 0, 0, 8'h05);
    cyc(32'h1008, 0, 0, 0, 8'h06);
    cyc(32'h1004, 0, 0, 0, 8'h06);

    cur_req = "R4";
    wr(4'd6, 32'h2000); wr(4'd7, 32'h20FF); wr(4'd8, 32'h0); wr(4'd14, 32'h1);
    cyc(0, 32'h1FFF, 0, 0, 0);
    cyc(0, 32'h2000, 0, 0, 0);
    cyc(0, 32'h20FF, 0, 0, 0);
    cyc(0, 32'h2100, 0, 0, 0);

    cur_req = "R5";
    wr(4'd9, 32'h0); wr(4'd10, 32'hFFFF_FFFF); wr(4'd11, 32'h0000_F03C); wr(4'd14, 32'h3);
    cyc(0, 32'h5000, 0, 8'h35, 0);
    cyc(0, 32'h5000, 0, 8'h45, 0);

    cur_req = "R6";
    cyc(0, 32'h5000, 0, 8'h35, 8'h77);
    wr(4'd11, 32'h0109_F03C);
    cyc(0, 32'h5000, 0, 8'h35, 8'h09);
    cyc(0, 32'h5000, 0, 8'h35, 8'h08);

    cur_req = "R7";
    wr(4'd12, 32'hDEAD_BEEF); wr(4'd13, 32'h0000_FFFF); wr(4'd14, 32'h7);
    cyc(0, 0, 32'hDEAD_0000, 0, 0);
    cyc(0, 0, 32'hDEAE_BEEF, 0, 0);
    cyc(0, 0, 32'hDEAD_1234, 0, 0);

    cur_req = "R9";
    cyc(32'h1000, 32'h2000, 32'hDEAD_0000, 8'h35, 8'h09);

    cur_req = "R8";
    @(negedge clk);
    bus_valid = 1'b0; bus_pc = 32'h1000; bus_addr = 32'h2000; bus_data = 32'hDEAD_0000;
    repeat (2) @(negedge clk);

    cur_req = "R10";
    wr(4'd8, 32'h0000_FF11);
    cyc(0, 32'h2500, 0, 8'h11, 0);
    cmd(1'b0, 32'h3000, 8'h22, 32'h0);
    cyc(0, 32'h2500, 0, 8'h22, 0);
    cur_req = "R12";
    cyc(0, 32'h2050, 0, 8'h11, 0);

    cur_req = "R11";
    cmd(1'b1, 32'h2010, 8'h11, 32'h1234_5678);
    cyc(0, 0, 32'h1234_0000, 0, 0);
    cur_req = "R12";
    cyc(0, 0, 32'hDEAD_0000, 0, 0);
    cyc(0, 32'h2080, 0, 8'h11, 0);

    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL %s watchdog: actual=running expected=finished", cur_req);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule